// File: doc/BRIEF.md
# Memory Data-Line Test Sequencer

This block is a hardware engine that tests the data lines of a 64-bit memory for shorts and opens. It has a simple synchronous master port for the memory. After a start pulse it runs a fixed table of twelve bit patterns against one word of memory. The patterns are chosen so that every pair of data lines is driven to opposite levels at some point, whatever the board routing.

For each pattern the engine first writes the pattern to the base word. It then writes a decoy word to the next address, so that the bus no longer holds the value under test. Only after that does it read the base word back. The one captured read value is the value that gets compared. A mismatch does not stop the run. The fail flag collects every mismatch. For the most recent mismatch the engine keeps the expected word, the observed word and the pattern index, so that a faulty byte lane shows up as decoy bytes inside the read value.

Top module: `dlt_engine`

## Requirements
- R1: While reset is held, and on its release, no memory request is made; busy, done and fail are 0; the expected word, observed word and mismatch index are 0.
- R2: The patterns run in a fixed order by index. Indices 0 to 5 are AAAAAAAAAAAAAAAA, CCCCCCCCCCCCCCCC, F0F0F0F0F0F0F0F0, FF00FF00FF00FF00, FFFF0000FFFF0000 and FFFFFFFF00000000 (hex). Indices 6 to 11 are the one's complements of indices 5 down to 0.
- R3: For each pattern the memory port carries three requests in three consecutive cycles: a write of the pattern to the base address, a write of 0123456789ABCDEF to the base address plus one (wrapping modulo the address width), and then a read of the base address. A request is a cycle with mem_req_o high; mem_we_o high marks a write.
- R4: Each pattern issues exactly one read. No request is issued from the read until mem_rvalid_i returns, so a run makes exactly 36 requests.
- R5: Read data is sampled only in the cycle mem_rvalid_i is high. Any mismatch sets fail_o, which stays set for the rest of the run. All twelve patterns always run.
- R6: On each mismatch, exp_o takes the pattern, obs_o takes the read word and fail_idx_o takes the pattern index. These outputs hold their values until the next mismatch, and a new start does not clear them.
- R7: done_o rises after the twelfth read returns and stays high until the next accepted start. An accepted start clears done_o and fail_o.
- R8: A start pulse while busy_o is high has no effect on the running sequence or on its address.
- R9: mem_rvalid_i while no read is pending has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| base_addr_i | input | AW | Word address under test, latched on start |
| mem_req_o | output | 1 | Memory request, taken in the same cycle |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | AW | Word address |
| mem_wdata_o | output | 64 | Write data |
| mem_rdata_i | input | 64 | Read data, valid with mem_rvalid_i |
| mem_rvalid_i | input | 1 | Read data valid |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence finished, held until next start |
| fail_o | output | 1 | Sticky OR of all mismatches in the run |
| exp_o | output | 64 | Expected word of latest mismatch |
| obs_o | output | 64 | Observed word of latest mismatch |
| fail_idx_o | output | 4 | Pattern index of latest mismatch |

## Verification
The assertions assume that the memory accepts every request in the cycle it is made. They also assume that at most one read response comes back for each read, no earlier than the cycle after that read. The bench responder follows this: it answers each read exactly once, after a programmable latency of one cycle or more. It injects stray valid pulses only while the engine is idle, and a stray pulse there must be ignored. Faults are modelled inside the responder, as bit flips on chosen reads and as a floating bus that returns the last word written, so the sequencer itself always sees a legal port.

// File: rtl/dlt_pkg.sv
package dlt_pkg;
  localparam int DW    = 64;
  localparam int NPAT  = 12;
  localparam int IW    = $clog2(NPAT);
  localparam logic [DW-1:0] DECOY = 64'h0123_4567_89AB_CDEF;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WR_PAT, ST_WR_DECOY, ST_RD_REQ, ST_RD_WAIT
  } seq_st_e;

  // Pattern k<6: bit i equals address bit k of i; k>=6: complement of pattern 11-k
  function automatic logic [DW-1:0] pat_word(input logic [IW-1:0] k);
    logic [DW-1:0] w;
    int            sel;
    logic          inv;
    inv = (k >= IW'(NPAT/2));
    sel = inv ? (NPAT - 1 - int'(k)) : int'(k);
    for (int i = 0; i < DW; i++) begin
      w[i] = (((i >> sel) & 1) != 0) ^ inv;
    end
    return w;
  endfunction
endpackage

// File: rtl/dlt_rst_sync.sv
module dlt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/dlt_pattern_sel.sv
module dlt_pattern_sel
  import dlt_pkg::*;
(
  input  logic [IW-1:0] idx_i,
  input  logic          decoy_i,
  output logic [DW-1:0] pat_o,
  output logic [DW-1:0] wdata_o
);
  always_comb begin
    pat_o   = pat_word(idx_i);
    wdata_o = decoy_i ? DECOY : pat_o;
  end
endmodule

// File: rtl/dlt_seq_ctrl.sv
module dlt_seq_ctrl
  import dlt_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] base_i,
  input  logic          rvalid_i,
  output logic [IW-1:0] idx_o,
  output logic          decoy_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic          start_acc_o,
  output logic          cmp_en_o,
  output logic          busy_o,
  output logic          done_o
);
  localparam logic [IW-1:0] LAST = IW'(NPAT - 1);

  seq_st_e       st_q, st_n;
  logic [IW-1:0] idx_q, idx_n;
  logic [AW-1:0] base_q;
  logic          done_q, done_n;
  logic          idx_en;

  always_comb begin
    st_n   = st_q;
    idx_n  = idx_q;
    done_n = done_q;
    idx_en = 1'b0;
    case (st_q)
      ST_IDLE: if (start_i) begin
        st_n   = ST_WR_PAT;
        idx_n  = '0;
        idx_en = 1'b1;
        done_n = 1'b0;
      end
      ST_WR_PAT:   st_n = ST_WR_DECOY;
      ST_WR_DECOY: st_n = ST_RD_REQ;
      ST_RD_REQ:   st_n = ST_RD_WAIT;
      ST_RD_WAIT: if (rvalid_i) begin
        if (idx_q == LAST) begin
          st_n   = ST_IDLE;
          done_n = 1'b1;
        end else begin
          st_n   = ST_WR_PAT;
          idx_n  = idx_q + 1'b1;
          idx_en = 1'b1;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      base_q <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      done_q <= done_n;
      if (idx_en)      idx_q  <= idx_n;
      if (start_acc_o) base_q <= base_i;
    end
  end

  always_comb begin
    start_acc_o = (st_q == ST_IDLE) && start_i;
    cmp_en_o    = (st_q == ST_RD_WAIT) && rvalid_i;
    busy_o      = (st_q != ST_IDLE);
    decoy_o     = (st_q == ST_WR_DECOY);
    mem_req_o   = (st_q == ST_WR_PAT) || (st_q == ST_WR_DECOY) || (st_q == ST_RD_REQ);
    mem_we_o    = (st_q == ST_WR_PAT) || (st_q == ST_WR_DECOY);
    mem_addr_o  = decoy_o ? base_q + 1'b1 : base_q;
    idx_o       = idx_q;
    done_o      = done_q;
  end

  AST_DECOY_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && mem_we_o && !decoy_o) |=>
      (mem_req_o && mem_we_o && decoy_o && mem_addr_o == AW'($past(mem_addr_o) + 1'b1))); // R3
  AST_ONE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_we_o) |=> !mem_req_o); // R4
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !mem_req_o); // R7
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> $stable(base_q)); // R8
  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= LAST); // R2
endmodule

// File: rtl/dlt_mismatch_log.sv
module dlt_mismatch_log
  import dlt_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          cmp_en_i,
  input  logic [DW-1:0] exp_i,
  input  logic [DW-1:0] obs_i,
  input  logic [IW-1:0] idx_i,
  output logic          fail_o,
  output logic [DW-1:0] exp_o,
  output logic [DW-1:0] obs_o,
  output logic [IW-1:0] idx_o
);
  logic mis;
  logic fail_n;

  always_comb begin
    mis    = cmp_en_i && (obs_i != exp_i);
    fail_n = clr_i ? 1'b0 : (fail_o | mis);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail_o <= 1'b0;
      exp_o  <= '0;
      obs_o  <= '0;
      idx_o  <= '0;
    end else begin
      fail_o <= fail_n;
      if (mis) begin
        exp_o <= exp_i;
        obs_o <= obs_i;
        idx_o <= idx_i;
      end
    end
  end

  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_o && !clr_i) |=> fail_o); // R5
  AST_LOG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmp_en_i && exp_i != obs_i) |=> ($stable(exp_o) && $stable(obs_o) && $stable(idx_o))); // R6
  AST_LOG_IDX: assert property (@(posedge clk) disable iff (!rst_n)
    idx_o < IW'(NPAT)); // R6
endmodule

// File: rtl/dlt_engine.sv
module dlt_engine
  import dlt_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] base_addr_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [63:0]   mem_wdata_o,
  input  logic [63:0]   mem_rdata_i,
  input  logic          mem_rvalid_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          fail_o,
  output logic [63:0]   exp_o,
  output logic [63:0]   obs_o,
  output logic [3:0]    fail_idx_o
);
  logic          rst_i_n;
  logic [IW-1:0] idx;
  logic          decoy;
  logic          start_acc;
  logic          cmp_en;
  logic [DW-1:0] pat;

  dlt_rst_sync u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n)
  );

  dlt_seq_ctrl #(.AW(AW)) u_ctrl (
    .clk(clk), .rst_n(rst_i_n), .start_i(start_i), .base_i(base_addr_i),
    .rvalid_i(mem_rvalid_i), .idx_o(idx), .decoy_o(decoy),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .start_acc_o(start_acc), .cmp_en_o(cmp_en), .busy_o(busy_o), .done_o(done_o)
  );

  dlt_pattern_sel u_pat (
    .idx_i(idx), .decoy_i(decoy), .pat_o(pat), .wdata_o(mem_wdata_o)
  );

  dlt_mismatch_log u_log (
    .clk(clk), .rst_n(rst_i_n), .clr_i(start_acc), .cmp_en_i(cmp_en),
    .exp_i(pat), .obs_i(mem_rdata_i), .idx_i(idx),
    .fail_o(fail_o), .exp_o(exp_o), .obs_o(obs_o), .idx_o(fail_idx_o)
  );

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_i_n |-> (!mem_req_o && !done_o && !fail_o)); // R1
endmodule

// File: tb/sim_dlt_engine.sv
module sim_dlt_engine;
  localparam int AW = 16;
  localparam logic [63:0] DECOY_W = 64'h0123456789ABCDEF;

  typedef struct packed {
    logic          we;
    logic [AW-1:0] addr;
    logic [63:0]   data;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [AW-1:0] base_addr_i = '0;
  logic mem_req_o, mem_we_o;
  logic [AW-1:0] mem_addr_o;
  logic [63:0] mem_wdata_o;
  logic [63:0] mem_rdata_i = '0;
  logic mem_rvalid_i = 1'b0;
  logic busy_o, done_o, fail_o;
  logic [63:0] exp_o, obs_o;
  logic [3:0] fail_idx_o;

  always #10 clk = ~clk; // 50 MHz

  dlt_engine #(.AW(AW)) u0 (.*);

  logic [63:0] pats [12] = '{
    64'hAAAAAAAAAAAAAAAA, 64'hCCCCCCCCCCCCCCCC, 64'hF0F0F0F0F0F0F0F0,
    64'hFF00FF00FF00FF00, 64'hFFFF0000FFFF0000, 64'hFFFFFFFF00000000,
    64'h00000000FFFFFFFF, 64'h0000FFFF0000FFFF, 64'h00FF00FF00FF00FF,
    64'h0F0F0F0F0F0F0F0F, 64'h3333333333333333, 64'h5555555555555555};

  item_t       sb_q [$];
  int          n_chk = 0;
  int          n_bad = 0;
  logic [63:0] mem_m [logic [AW-1:0]];
  logic [63:0] fmask [12];
  logic [63:0] last_wr = '0;
  bit          float_bus = 0;
  int          lat = 1;
  int          rd_num = 0;
  bit          rd_pend = 0;
  int          rd_wait = 0;
  logic [63:0] rd_word = '0;
  bit          junk = 0;
  bit          finished = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  // Monitor: pops expected requests and models the memory
  always @(negedge clk) begin
    mem_rvalid_i = 1'b0;
    if (rd_pend) begin
      if (rd_wait <= 1) begin
        mem_rvalid_i = 1'b1; mem_rdata_i = rd_word; rd_pend = 0;
      end else rd_wait--;
    end else if (junk) begin
      mem_rvalid_i = 1'b1; mem_rdata_i = 64'hDEAD_BEEF_0000_1111; junk = 0;
    end
    if (rst_n && mem_req_o) begin
      if (sb_q.size() == 0) begin
        chk(0, "R4 extra request", {63'd0, mem_we_o}, 64'd0);
      end else begin
        item_t e;
        e = sb_q.pop_front();
        chk(mem_we_o == e.we && mem_addr_o == e.addr && (!e.we || mem_wdata_o == e.data),
            "R2/R3 request", {mem_we_o, 15'd0, mem_addr_o, mem_wdata_o[31:0]},
            {e.we, 15'd0, e.addr, e.data[31:0]});
      end
      if (mem_we_o) begin
        mem_m[mem_addr_o] = mem_wdata_o; last_wr = mem_wdata_o;
      end else begin
        rd_word = float_bus ? last_wr : (mem_m[mem_addr_o] ^ fmask[rd_num % 12]);
        rd_num++; rd_pend = 1; rd_wait = lat;
      end
    end
  end

  // Driver: pushes the 36 expected requests, then pulses start
  task automatic run_seq(input logic [AW-1:0] base);
    rd_num = 0;
    for (int k = 0; k < 12; k++) begin
      sb_q.push_back('{1'b1, base, pats[k]});
      sb_q.push_back('{1'b1, AW'(base + 1'b1), DECOY_W});
      sb_q.push_back('{1'b0, base, 64'd0});
    end
    base_addr_i = base; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(!done_o && !fail_o && busy_o, "R7 start clears", {62'd0, done_o, fail_o}, 64'd0);
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done_o && n < 3000) begin @(negedge clk); n++; end
    chk(done_o, "R7 done", {63'd0, done_o}, 64'd1);
    chk(sb_q.size() == 0 && rd_num == 12, "R4 request count",
        64'(sb_q.size()*100 + rd_num), 64'd12);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] m7;
    for (int i = 0; i < 12; i++) fmask[i] = '0;
    repeat (3) @(negedge clk);
    chk(!mem_req_o && !busy_o && !done_o && !fail_o, "R1 reset flags",
        {60'd0, mem_req_o, busy_o, done_o, fail_o}, 64'd0);
    chk(exp_o == 0 && obs_o == 0 && fail_idx_o == 0, "R1 reset log", exp_o | obs_o, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!mem_req_o && !busy_o && !done_o, "R1 after release", {61'd0, mem_req_o, busy_o, done_o}, 64'd0);

    // R9: stray read-valid while idle
    junk = 1;
    repeat (3) @(negedge clk);
    chk(!fail_o && !busy_o && obs_o == 0 && !mem_req_o, "R9 stray valid", obs_o, 64'd0);

    // Clean run, minimum latency
    lat = 1;
    run_seq(16'h0005);
    wait_done();
    chk(!fail_o && exp_o == 0 && obs_o == 0, "R5 clean run", {63'd0, fail_o}, 64'd0);
    repeat (20) @(negedge clk);
    chk(done_o && !busy_o, "R7 done held", {62'd0, done_o, busy_o}, 64'd2);

    // Bit flips on reads 2 and 9, top address wrap, start while busy
    lat = 4;
    fmask[2] = 64'h0000_0000_0000_8000;
    fmask[9] = 64'h0000_0100_0000_0000;
    run_seq(16'hFFFF);
    repeat (10) @(negedge clk);
    base_addr_i = 16'h1234; start_i = 1'b1;  // R8: must be ignored
    @(negedge clk);
    start_i = 1'b0;
    wait_done();
    chk(fail_o, "R5 sticky fail", {63'd0, fail_o}, 64'd1);
    chk(fail_idx_o == 4'd9, "R6 last index", 64'(fail_idx_o), 64'd9);
    chk(exp_o == pats[9], "R6 expected word", exp_o, pats[9]);
    m7 = pats[9] ^ fmask[9];
    chk(obs_o == m7, "R6 observed word", obs_o, m7);
    fmask[2] = '0; fmask[9] = '0;

    // Clean run: fail clears, log holds
    lat = 2;
    run_seq(16'h0100);
    wait_done();
    chk(!fail_o, "R7 fail cleared", {63'd0, fail_o}, 64'd0);
    chk(exp_o == pats[9] && obs_o == m7 && fail_idx_o == 4'd9, "R6 log held", obs_o, m7);

    // Floating bus: every read returns the last written word (the decoy)
    float_bus = 1; lat = 1;
    run_seq(16'h0020);
    wait_done();
    chk(fail_o && fail_idx_o == 4'd11, "R3 decoy exposes float", 64'(fail_idx_o), 64'd11);
    chk(obs_o == DECOY_W && exp_o == pats[11], "R3 decoy observed", obs_o, DECOY_W);
    float_bus = 0;

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule